// File: doc/BRIEF.md
# Instruction-Boundary Event Arbiter

This block sits between the execution stage and the interrupt-entry sequencer of a processor core. At each instruction boundary it looks at every pending event and picks the single one to service. Events come from three places:

- exception reports about the instruction that just ran or is about to restart,
- the single-step flag,
- two external request pins: one rising-edge sensed, one level sensed.

When it picks an event, the block hands the entry sequencer a vector number and a tag. The tag tells the sequencer whether the saved return point is the faulting instruction (restart) or the instruction after it (no restart).

Requests on the maskable pin have no fixed vector. The block runs a short acknowledge handshake with an external interrupt controller and takes the vector byte that the controller places on its data lines. After a selection the block stays busy, and ignores further boundaries, until the sequencer reports that the entry is complete.

Top module: `boundary_event_arb`

## Requirements
- R1: While reset is high, and in the first cycle after it, `disp_valid`, `inta_o` and `busy` are all 0.
- R2: A divide error (`div_err`) at a boundary is dispatched with vector 0 and `disp_fault`=1. It wins over every other event.
- R3: With no fault, an executed software interrupt (`swi_exec`) is dispatched with vector equal to `swi_num` and `disp_fault`=0. It wins over R4 and R5.
- R4: With no fault and no software interrupt, a completed opcode (`ret_opcode`) equal to 0xCC is dispatched as vector 3 with `disp_fault`=0.
- R5: The conditional overflow instruction (`into_exec`) is dispatched as vector 4 with `disp_fault`=0 only when `ovf_flag` is 1. When `ovf_flag` is 0 it produces nothing.
- R6: When no fault or instruction trap is present and `trap_flag` is 1, vector 1 is dispatched with `disp_fault`=0.
- R7: A rising edge on `nmi_pin` is latched until it is serviced. It is then dispatched as vector 2, whatever `ie_flag` is, below R2 to R6. A pin held high yields exactly one event.
- R8: If nothing above is pending, `intr_pin`=1 and `ie_flag`=1, then `inta_o` is high for exactly two cycles. The `ack_data` value present in the second of those cycles becomes the vector, with `disp_fault`=0. If `ie_flag` is 0, the maskable pin is ignored.
- R9: `busy` rises with a selection and stays high until a `seq_done` seen while the result is held. Boundaries that arrive while `busy` is high are ignored.
- R10: `disp_valid` is a one-cycle pulse. For an immediate event it comes in the cycle after the boundary; for a maskable event it comes in the cycle after the second acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_strobe | input | 1 | Instruction boundary; the event inputs are valid |
| div_err | input | 1 | Divide quotient overflow in the current instruction |
| swi_exec | input | 1 | Completed instruction was a software interrupt |
| swi_num | input | VEC_W | Immediate vector of that software interrupt |
| ret_opcode | input | OP_W | Opcode byte of the completed instruction |
| into_exec | input | 1 | Completed instruction was the conditional overflow trap |
| ovf_flag | input | 1 | Overflow flag |
| trap_flag | input | 1 | Single-step flag |
| ie_flag | input | 1 | Interrupt-enable flag |
| nmi_pin | input | 1 | Non-maskable request, rising-edge sensed |
| intr_pin | input | 1 | Maskable request, level sensed |
| ack_data | input | VEC_W | Vector byte from the interrupt controller |
| seq_done | input | 1 | Entry sequencer finished |
| inta_o | output | 1 | Interrupt acknowledge to the controller |
| disp_valid | output | 1 | Dispatch strobe |
| disp_vector | output | VEC_W | Selected vector |
| disp_fault | output | 1 | 1 = fault (restart the instruction), 0 = trap |
| busy | output | 1 | Selection in progress; boundaries are ignored |

## Verification
The assertions check the following on every cycle:
- the dispatch strobe is always a single-cycle pulse inside a busy window;
- busy cannot drop without `seq_done`;
- the acknowledge pulse is exactly two cycles wide, and it starts only after a request seen with interrupts enabled;
- a divide error or software interrupt turns into the right vector one cycle later.

Only the bench scenarios can show the rest:
- the full priority order among several simultaneous events;
- the one-event-per-edge behaviour of a held non-maskable pin;
- the silence of a masked or non-overflowing request;
- boundaries being dropped while the sequencer has not yet answered.

// File: rtl/iba_pkg.sv
package iba_pkg;
  typedef enum logic [2:0] {
    EV_NONE, EV_FAULT, EV_TRAP, EV_STEP, EV_NMI, EV_MASK
  } ev_e;

  localparam int VEC_DIVIDE = 0;
  localparam int VEC_STEP   = 1;
  localparam int VEC_NMI    = 2;
  localparam int VEC_BKPT   = 3;
  localparam int VEC_OVF    = 4;
  localparam int BKPT_OP    = 'hCC;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic take,
  output logic pending
);
  logic pin_q;
  logic rise;

  assign rise = pin & ~pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      pin_q   <= pin;
      // a new edge arriving in the same cycle as service stays latched
      pending <= (pending & ~take) | rise;
    end
  end
endmodule

// File: rtl/event_select.sv
module event_select
  import iba_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int OP_W  = 8
) (
  input  logic             div_err,
  input  logic             swi_exec,
  input  logic [VEC_W-1:0] swi_num,
  input  logic [OP_W-1:0]  ret_opcode,
  input  logic             into_exec,
  input  logic             ovf_flag,
  input  logic             trap_flag,
  input  logic             nmi_pend,
  input  logic             intr_pin,
  input  logic             ie_flag,
  output ev_e              kind,
  output logic [VEC_W-1:0] vec,
  output logic             fault
);
  localparam logic [OP_W-1:0] BKPT = OP_W'(BKPT_OP);

  always_comb begin
    kind  = EV_NONE;
    vec   = '0;
    fault = 1'b0;
    if (div_err) begin
      kind  = EV_FAULT;
      vec   = VEC_W'(VEC_DIVIDE);
      fault = 1'b1;
    end else if (swi_exec) begin
      kind = EV_TRAP;
      vec  = swi_num;
    end else if (ret_opcode == BKPT) begin
      kind = EV_TRAP;
      vec  = VEC_W'(VEC_BKPT);
    end else if (into_exec && ovf_flag) begin
      kind = EV_TRAP;
      vec  = VEC_W'(VEC_OVF);
    end else if (trap_flag) begin
      kind = EV_STEP;
      vec  = VEC_W'(VEC_STEP);
    end else if (nmi_pend) begin
      kind = EV_NMI;
      vec  = VEC_W'(VEC_NMI);
    end else if (intr_pin && ie_flag) begin
      kind = EV_MASK;
    end
  end
endmodule

// File: rtl/ack_sequencer.sv
module ack_sequencer #(
  parameter int VEC_W      = 8,
  parameter int ACK_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_imm,
  input  logic [VEC_W-1:0] imm_vec,
  input  logic             imm_fault,
  input  logic             start_ack,
  input  logic [VEC_W-1:0] ack_data,
  input  logic             seq_done,
  output logic             inta,
  output logic             disp_valid,
  output logic [VEC_W-1:0] disp_vector,
  output logic             disp_fault,
  output logic             busy
);
  localparam int CW = $clog2(ACK_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_ACK, S_HOLD} st_e;
  st_e           st;
  logic [CW-1:0] cnt;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cnt         <= '0;
      inta        <= 1'b0;
      disp_valid  <= 1'b0;
      disp_vector <= '0;
      disp_fault  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_imm) begin
            disp_valid  <= 1'b1;
            disp_vector <= imm_vec;
            disp_fault  <= imm_fault;
            st          <= S_HOLD;
          end else if (start_ack) begin
            inta <= 1'b1;
            cnt  <= CW'(1);
            st   <= S_ACK;
          end
        end
        S_ACK: begin
          if (cnt == CW'(ACK_CYCLES)) begin
            inta        <= 1'b0;
            disp_valid  <= 1'b1;
            disp_vector <= ack_data;
            disp_fault  <= 1'b0;
            st          <= S_HOLD;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          disp_valid <= 1'b0;
          if (seq_done) st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/boundary_event_arb.sv
module boundary_event_arb
  import iba_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int OP_W       = 8,
  parameter int ACK_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bnd_strobe,
  input  logic             div_err,
  input  logic             swi_exec,
  input  logic [VEC_W-1:0] swi_num,
  input  logic [OP_W-1:0]  ret_opcode,
  input  logic             into_exec,
  input  logic             ovf_flag,
  input  logic             trap_flag,
  input  logic             ie_flag,
  input  logic             nmi_pin,
  input  logic             intr_pin,
  input  logic [VEC_W-1:0] ack_data,
  input  logic             seq_done,
  output logic             inta_o,
  output logic             disp_valid,
  output logic [VEC_W-1:0] disp_vector,
  output logic             disp_fault,
  output logic             busy
);
  logic             nmi_pend;
  logic             nmi_take;
  ev_e              kind;
  logic [VEC_W-1:0] sel_vec;
  logic             sel_fault;
  logic             decide;
  logic             go_imm;
  logic             go_ack;

  assign decide   = bnd_strobe & ~busy;
  assign nmi_take = decide & (kind == EV_NMI);
  assign go_ack   = decide & (kind == EV_MASK);
  assign go_imm   = decide & (kind != EV_NONE) & (kind != EV_MASK);

  nmi_edge_latch u_nmi (
    .clk     (clk),
    .rst     (rst),
    .pin     (nmi_pin),
    .take    (nmi_take),
    .pending (nmi_pend)
  );

  event_select #(.VEC_W(VEC_W), .OP_W(OP_W)) u_sel (
    .div_err    (div_err),
    .swi_exec   (swi_exec),
    .swi_num    (swi_num),
    .ret_opcode (ret_opcode),
    .into_exec  (into_exec),
    .ovf_flag   (ovf_flag),
    .trap_flag  (trap_flag),
    .nmi_pend   (nmi_pend),
    .intr_pin   (intr_pin),
    .ie_flag    (ie_flag),
    .kind       (kind),
    .vec        (sel_vec),
    .fault      (sel_fault)
  );

  ack_sequencer #(.VEC_W(VEC_W), .ACK_CYCLES(ACK_CYCLES)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_imm   (go_imm),
    .imm_vec     (sel_vec),
    .imm_fault   (sel_fault),
    .start_ack   (go_ack),
    .ack_data    (ack_data),
    .seq_done    (seq_done),
    .inta        (inta_o),
    .disp_valid  (disp_valid),
    .disp_vector (disp_vector),
    .disp_fault  (disp_fault),
    .busy        (busy)
  );
endmodule

// File: rtl/iba_checker.sv
module iba_checker #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bnd_strobe,
  input logic             div_err,
  input logic             swi_exec,
  input logic [VEC_W-1:0] swi_num,
  input logic             ie_flag,
  input logic             intr_pin,
  input logic [VEC_W-1:0] ack_data,
  input logic             seq_done,
  input logic             inta_o,
  input logic             disp_valid,
  input logic [VEC_W-1:0] disp_vector,
  input logic             disp_fault,
  input logic             busy
);
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    disp_valid |=> !disp_valid);

  p_valid_busy_r9: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> busy);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy && !seq_done |=> busy);

  p_div_fault_r2: assert property (@(posedge clk) disable iff (rst)
    bnd_strobe && !busy && div_err |=> disp_valid && disp_fault && disp_vector == '0);

  p_swi_trap_r3: assert property (@(posedge clk) disable iff (rst)
    bnd_strobe && !busy && !div_err && swi_exec |=>
      disp_valid && !disp_fault && disp_vector == $past(swi_num));

  p_ack_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(inta_o) |=> inta_o);

  p_ack_end_r8: assert property (@(posedge clk) disable iff (rst)
    inta_o && $past(inta_o) |=> !inta_o && disp_valid && disp_vector == $past(ack_data));

  p_ack_enabled_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(inta_o) |-> $past(ie_flag) && $past(intr_pin));
endmodule

bind boundary_event_arb iba_checker #(.VEC_W(VEC_W)) u_iba_chk (
  .clk         (clk),
  .rst         (rst),
  .bnd_strobe  (bnd_strobe),
  .div_err     (div_err),
  .swi_exec    (swi_exec),
  .swi_num     (swi_num),
  .ie_flag     (ie_flag),
  .intr_pin    (intr_pin),
  .ack_data    (ack_data),
  .seq_done    (seq_done),
  .inta_o      (inta_o),
  .disp_valid  (disp_valid),
  .disp_vector (disp_vector),
  .disp_fault  (disp_fault),
  .busy        (busy)
);

// File: tb/boundary_event_arb_test.sv
module boundary_event_arb_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bnd_strobe = 0, div_err = 0, swi_exec = 0, into_exec = 0, ovf_flag = 0;
  logic       trap_flag = 0, ie_flag = 0, nmi_pin = 0, intr_pin = 0, seq_done = 0;
  logic [7:0] swi_num = 0, ret_opcode = 0, ack_data = 0;
  logic       inta_o, disp_valid, disp_fault, busy;
  logic [7:0] disp_vector;

  int n_run = 0;
  int n_fail = 0;
  bit nmi_prev = 0;
  bit nmi_pend_m = 0;

  always #10 clk = ~clk;

  boundary_event_arb uut (
    .clk(clk), .rst(rst), .bnd_strobe(bnd_strobe), .div_err(div_err),
    .swi_exec(swi_exec), .swi_num(swi_num), .ret_opcode(ret_opcode),
    .into_exec(into_exec), .ovf_flag(ovf_flag), .trap_flag(trap_flag),
    .ie_flag(ie_flag), .nmi_pin(nmi_pin), .intr_pin(intr_pin),
    .ack_data(ack_data), .seq_done(seq_done), .inta_o(inta_o),
    .disp_valid(disp_valid), .disp_vector(disp_vector),
    .disp_fault(disp_fault), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock, with the bench's own model of the edge-sensed pin
  task automatic tick(input bit took_nmi);
    @(posedge clk);
    nmi_pend_m = (nmi_pend_m & ~took_nmi) | (nmi_pin & ~nmi_prev);
    nmi_prev   = nmi_pin;
    @(negedge clk);
  endtask

  // kinds: 0 none, 1 fault, 2 trap, 3 step, 4 nmi, 5 maskable
  function automatic int predict(output logic [7:0] v, output bit f);
    v = 8'd0; f = 1'b0;
    if (div_err)                    begin f = 1'b1; return 1; end
    if (swi_exec)                   begin v = swi_num; return 2; end
    if (ret_opcode == 8'hCC)        begin v = 8'd3; return 2; end
    if (into_exec && ovf_flag)      begin v = 8'd4; return 2; end
    if (trap_flag)                  begin v = 8'd1; return 3; end
    if (nmi_pend_m)                 begin v = 8'd2; return 4; end
    if (intr_pin && ie_flag)        return 5;
    return 0;
  endfunction

  function automatic string req_of(input int k);
    case (k)
      1: return "R2";
      2: return swi_exec ? "R3" : (ret_opcode == 8'hCC) ? "R4" : "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R5/R7/R8 no-event";
    endcase
  endfunction

  task automatic do_boundary(input bit hold_busy);
    int k; logic [7:0] ev; bit ef; string rq; logic [7:0] d;
    k  = predict(ev, ef);
    rq = req_of(k);
    bnd_strobe = 1'b1;
    tick(k == 4);
    bnd_strobe = 1'b0;
    if (k == 0) begin
      check(!disp_valid && !busy && !inta_o, rq, "no event expected",
            {disp_valid, busy, inta_o}, 0);
    end else if (k == 5) begin
      check(inta_o && !disp_valid, "R8", "ack cycle 1", {inta_o, disp_valid}, 2);
      d = 8'($urandom);
      ack_data = d;
      tick(1'b0);
      check(inta_o && !disp_valid, "R8", "ack cycle 2", {inta_o, disp_valid}, 2);
      tick(1'b0);
      check(disp_valid && !inta_o && !disp_fault, "R10", "ack dispatch strobe",
            {disp_valid, inta_o, disp_fault}, 4);
      check(disp_vector == d, "R8", "captured vector", disp_vector, d);
    end else begin
      check(disp_valid && busy, "R10", "dispatch strobe", {disp_valid, busy}, 3);
      check(disp_vector == ev, rq, "vector", disp_vector, ev);
      check(disp_fault == ef, rq, "fault tag", disp_fault, ef);
    end
    if (k != 0) begin
      if (hold_busy) begin
        tick(1'b0);
        check(!disp_valid && busy, "R10", "strobe single cycle", {disp_valid, busy}, 1);
        div_err = 1'b1;
        bnd_strobe = 1'b1;
        tick(1'b0);
        bnd_strobe = 1'b0;
        div_err = 1'b0;
        tick(1'b0);
        check(!disp_valid && busy, "R9", "boundary ignored while busy",
              {disp_valid, busy}, 1);
      end
      seq_done = 1'b1;
      tick(1'b0);
      seq_done = 1'b0;
      check(!busy && !disp_valid, "R9", "released by done", {busy, disp_valid}, 0);
    end
  endtask

  task automatic clear_inputs();
    div_err = 0; swi_exec = 0; into_exec = 0; ovf_flag = 0; trap_flag = 0;
    intr_pin = 0; ie_flag = 0; ret_opcode = 8'h90; swi_num = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not finish (all requirements)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_inputs();
    repeat (3) @(negedge clk);
    check(!disp_valid && !inta_o && !busy, "R1", "in reset", {disp_valid, inta_o, busy}, 0);
    rst = 1'b0;
    tick(1'b0);
    check(!disp_valid && !inta_o && !busy, "R1", "after reset", {disp_valid, inta_o, busy}, 0);

    // R2: fault beats every trap source
    div_err = 1; swi_exec = 1; swi_num = 8'h80; trap_flag = 1; ret_opcode = 8'hCC;
    do_boundary(1'b0);
    clear_inputs();
    // R5: overflow trap suppressed without the flag, then taken with it
    into_exec = 1; ovf_flag = 0;
    do_boundary(1'b0);
    ovf_flag = 1;
    do_boundary(1'b0);
    clear_inputs();
    // R4: breakpoint opcode
    ret_opcode = 8'hCC;
    do_boundary(1'b0);
    clear_inputs();
    // R7: held pin -> exactly one event, even with interrupts disabled
    nmi_pin = 1;
    tick(1'b0);
    do_boundary(1'b0);
    do_boundary(1'b0);
    nmi_pin = 0;
    // R8: masked request is ignored, enabled one is acknowledged
    intr_pin = 1; ie_flag = 0;
    do_boundary(1'b0);
    ie_flag = 1;
    do_boundary(1'b0);
    clear_inputs();
    // R6 and R9: single step, with boundaries arriving while busy
    trap_flag = 1;
    do_boundary(1'b1);
    clear_inputs();

    for (int i = 0; i < 400; i++) begin
      div_err    = ($urandom % 8) == 0;
      swi_exec   = ($urandom % 8) == 0;
      swi_num    = 8'($urandom);
      ret_opcode = (($urandom % 6) == 0) ? 8'hCC : 8'($urandom % 200);
      into_exec  = ($urandom % 4) == 0;
      ovf_flag   = $urandom % 2;
      trap_flag  = ($urandom % 6) == 0;
      ie_flag    = $urandom % 2;
      intr_pin   = $urandom % 2;
      if (($urandom % 4) == 0) nmi_pin = ~nmi_pin;
      do_boundary(($urandom % 10) == 0);
      if (($urandom % 3) == 0) begin
        bnd_strobe = 1'b0;
        clear_inputs();
        tick(1'b0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule